// File: doc/BRIEF.md
# Wakeup-Select Instruction Window

This block holds renamed instructions until their two physical source operands are known to be available, then sends them to issue one per cycle. Each slot watches a result-tag broadcast bus; a producer places a destination tag on that bus one cycle before its data appears, so a slot whose source tag matches marks that operand available. Slots leave in whatever order they become ready, not in arrival order. Among the ready slots, the one with the lowest index is issued.

The sender sees a busy signal that rises while enough free slots remain to absorb the one instruction the sender may still launch before it reacts. A run-time enable switches the window off. While it is off and empty, each instruction passes straight to the issue register, one cycle after it is presented, whatever its operand state. When the enable drops while slots are still occupied, the block first drains those slots and only then changes to pass-through.

A three-state mode controller governs the block. The states are MODE_THRU (pass-through, window empty), MODE_WINDOW (window active) and MODE_DRAIN (window switched off but still occupied). The transitions are as follows:
- THRU to WINDOW when the enable is high.
- WINDOW to THRU when the enable is low and the window will be empty after the current edge.
- WINDOW to DRAIN when the enable is low and slots will remain.
- DRAIN to WINDOW when the enable returns.
- DRAIN to THRU when the window will be empty after the current edge.

Top module: `issue_window`

## Requirements
- R1: After reset, iss_valid and ins_busy are 0 and the block is in pass-through mode.
- R2: In pass-through mode, an instruction presented with ins_valid in cycle t appears on the iss_* outputs with iss_valid=1 in cycle t+1, with all fields unchanged, whatever its source-ready flags are. A broadcast in this mode causes no issue.
- R3: With the window enabled, an instruction inserted in cycle t with both ready flags set appears at issue in cycle t+2.
- R4: An inserted instruction with a source not ready does not issue until a broadcast (bc_valid=1) carries a matching tag in some cycle b while it is held. It then issues in cycle b+2. Once an operand is marked ready, it stays ready.
- R5: A broadcast in the same cycle as the insert counts for a matching source of the inserted instruction.
- R6: An instruction issues only when both sources are ready. Waking one source alone does not issue it.
- R7: An instruction with ins_fault=1 is treated as ready at once and issues in cycle t+2 with iss_fault=1.
- R8: At most one instruction issues per cycle. Instructions may leave in a different order than they arrived. When several are ready, the one in the lowest-index slot goes first. Slots are allocated lowest free index first.
- R9: ins_busy is 1 in window mode when the number of free slots is at most SLACK (default DEPTH=4, SLACK=1: busy when 3 or more slots are occupied). An instruction arriving in the cycle busy is raised is still accepted.
- R10: When the enable drops with slots occupied, ins_busy stays 1 while the remaining slots drain. The block returns to pass-through, with busy 0, at the edge that issues the last held instruction.
- R11: A slot freed by issue is reused by later inserts, so more than DEPTH instructions can pass through the window over time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_enable | input | 1 | 1 = window active, 0 = pass-through after draining |
| ins_valid | input | 1 | Instruction presented this cycle |
| ins_fault | input | 1 | Instruction carries a fault |
| ins_rid | input | RID_W | Reorder identifier |
| ins_op | input | OP_W | Operation code |
| ins_src_a | input | TAG_W | First physical source tag |
| ins_src_a_rdy | input | 1 | First source already available |
| ins_src_b | input | TAG_W | Second physical source tag |
| ins_src_b_rdy | input | 1 | Second source already available |
| ins_imm | input | IMM_W | Immediate |
| ins_dst | input | TAG_W | Physical destination tag |
| ins_busy | output | 1 | Back-pressure to the sender |
| bc_valid | input | 1 | Result tag broadcast valid |
| bc_tag | input | TAG_W | Broadcast tag; data follows next cycle |
| iss_valid | output | 1 | Issue output valid |
| iss_fault | output | 1 | Issued fault flag |
| iss_rid | output | RID_W | Issued reorder identifier |
| iss_op | output | OP_W | Issued operation code |
| iss_src_a | output | TAG_W | Issued first source tag |
| iss_src_b | output | TAG_W | Issued second source tag |
| iss_imm | output | IMM_W | Issued immediate |
| iss_dst | output | TAG_W | Issued destination tag |

## Verification
The hardest condition to reach is a full window that holds a late arrival accepted in the same cycle busy rose, while older entries wake out of order. The bench fills three slots with instructions whose sources are unready. It sends a fourth in the cycle busy first shows. It then broadcasts tags in an order that frees the youngest slot first, and wakes two slots together with one shared tag, which shows the lowest-index priority. The drain path is reached by dropping the enable while one slot still waits on a tag and then waking that slot. This shows that busy holds and that pass-through resumes on the very edge that issues the last entry.

// File: rtl/iw_pkg.sv
package iw_pkg;
    parameter int TAG_W = 6;
    parameter int RID_W = 6;
    parameter int OP_W  = 5;
    parameter int IMM_W = 16;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic             fault;
        logic [RID_W-1:0] rid;
        logic [OP_W-1:0]  op;
        tag_t             src_a;
        tag_t             src_b;
        logic [IMM_W-1:0] imm;
        tag_t             dst;
    } uop_t;

    typedef enum logic [1:0] {
        MODE_THRU   = 2'd0,
        MODE_WINDOW = 2'd1,
        MODE_DRAIN  = 2'd2
    } mode_e;
endpackage

// File: rtl/iw_pick.sv
module iw_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iw_slot.sv
module iw_slot
    import iw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  uop_t load_uop,
    input  logic load_a_rdy,
    input  logic load_b_rdy,
    input  logic leave,
    input  logic bc_valid,
    input  tag_t bc_tag,
    output logic occupied,
    output logic ready_o,
    output uop_t uop_o
);
    logic occ_q, a_q, b_q;
    uop_t uop_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= 1'b0;
            a_q   <= 1'b0;
            b_q   <= 1'b0;
            uop_q <= '0;
        end else if (load) begin
            occ_q <= 1'b1;
            uop_q <= load_uop;
            a_q   <= load_a_rdy | (bc_valid && bc_tag == load_uop.src_a);
            b_q   <= load_b_rdy | (bc_valid && bc_tag == load_uop.src_b);
        end else if (leave) begin
            occ_q <= 1'b0;
        end else if (occ_q && bc_valid) begin
            if (bc_tag == uop_q.src_a) a_q <= 1'b1;
            if (bc_tag == uop_q.src_b) b_q <= 1'b1;
        end
    end

    assign occupied = occ_q;
    assign ready_o  = occ_q && (uop_q.fault || (a_q && b_q));
    assign uop_o    = uop_q;

    AST_WAKE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !leave) |=> ready_o); // R4
    AST_LEAVE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        leave |-> ready_o); // R6
endmodule

// File: rtl/iw_ctrl.sv
module iw_ctrl
    import iw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  empty_next,
    input  logic  occ_zero,
    input  logic  near_full,
    output mode_e mode,
    output logic  pass,
    output logic  busy
);
    mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_THRU;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_THRU:   if (enable) state_d = MODE_WINDOW;
            MODE_WINDOW: if (!enable) state_d = empty_next ? MODE_THRU : MODE_DRAIN;
            MODE_DRAIN: begin
                if (enable)          state_d = MODE_WINDOW;
                else if (empty_next) state_d = MODE_THRU;
            end
            default:     state_d = MODE_THRU;
        endcase
    end

    always_comb begin
        mode = state_q;
        pass = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            MODE_THRU:   pass = 1'b1;
            MODE_WINDOW: busy = near_full;
            MODE_DRAIN:  busy = 1'b1;
            default:     pass = 1'b1;
        endcase
    end

    AST_THRU_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_THRU) |-> occ_zero); // R10
endmodule

// File: rtl/issue_window.sv
module issue_window
    import iw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SLACK = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_enable,
    input  logic             ins_valid,
    input  logic             ins_fault,
    input  logic [RID_W-1:0] ins_rid,
    input  logic [OP_W-1:0]  ins_op,
    input  logic [TAG_W-1:0] ins_src_a,
    input  logic             ins_src_a_rdy,
    input  logic [TAG_W-1:0] ins_src_b,
    input  logic             ins_src_b_rdy,
    input  logic [IMM_W-1:0] ins_imm,
    input  logic [TAG_W-1:0] ins_dst,
    output logic             ins_busy,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    output logic             iss_valid,
    output logic             iss_fault,
    output logic [RID_W-1:0] iss_rid,
    output logic [OP_W-1:0]  iss_op,
    output logic [TAG_W-1:0] iss_src_a,
    output logic [TAG_W-1:0] iss_src_b,
    output logic [IMM_W-1:0] iss_imm,
    output logic [TAG_W-1:0] iss_dst
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] occ_v, rdy_v, free_gnt, load_v, leave_v;
    logic             has_free, sel_any, win_ins, pass, empty_next, near_full;
    logic [CNT_W-1:0] occ_cnt;
    mode_e            mode;
    uop_t             ins_uop, sel_uop, iss_q;
    uop_t             slot_uop [DEPTH];

    assign ins_uop = '{fault: ins_fault, rid: ins_rid, op: ins_op,
                       src_a: ins_src_a, src_b: ins_src_b,
                       imm: ins_imm, dst: ins_dst};

    iw_pick #(.N(DEPTH)) i_alloc (.req(~occ_v), .gnt(free_gnt), .any(has_free));
    iw_pick #(.N(DEPTH)) i_select (.req(rdy_v), .gnt(leave_v), .any(sel_any));

    assign win_ins = ins_valid && !pass && has_free;
    assign load_v  = free_gnt & {DEPTH{win_ins}};

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iw_slot i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_v[g]),
            .load_uop  (ins_uop),
            .load_a_rdy(ins_src_a_rdy),
            .load_b_rdy(ins_src_b_rdy),
            .leave     (leave_v[g]),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .occupied  (occ_v[g]),
            .ready_o   (rdy_v[g]),
            .uop_o     (slot_uop[g])
        );
    end

    always_comb begin
        sel_uop = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (leave_v[i]) sel_uop = slot_uop[i];
        end
    end

    assign occ_cnt    = CNT_W'($countones(occ_v));
    assign near_full  = (DEPTH - int'(occ_cnt)) <= SLACK;
    assign empty_next = (int'(occ_cnt) - int'(sel_any) + int'(win_ins)) == 0;

    iw_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (win_enable),
        .empty_next(empty_next),
        .occ_zero  (occ_cnt == '0),
        .near_full (near_full),
        .mode      (mode),
        .pass      (pass),
        .busy      (ins_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_q     <= '0;
        end else if (pass) begin
            iss_valid <= ins_valid;
            iss_q     <= ins_uop;
        end else begin
            iss_valid <= sel_any;
            iss_q     <= sel_uop;
        end
    end

    assign iss_fault = iss_q.fault;
    assign iss_rid   = iss_q.rid;
    assign iss_op    = iss_q.op;
    assign iss_src_a = iss_q.src_a;
    assign iss_src_b = iss_q.src_b;
    assign iss_imm   = iss_q.imm;
    assign iss_dst   = iss_q.dst;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !pass) |-> has_free); // R9
    AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && ins_valid) |=> iss_valid); // R2
    AST_DRAIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DRAIN) |-> ins_busy); // R10
endmodule

// File: tb/test_issue_window.sv
module test_issue_window;
    import iw_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, win_enable, ins_valid, ins_fault, ins_src_a_rdy, ins_src_b_rdy;
    logic [RID_W-1:0] ins_rid, iss_rid;
    logic [OP_W-1:0]  ins_op, iss_op;
    logic [TAG_W-1:0] ins_src_a, ins_src_b, ins_dst, bc_tag;
    logic [TAG_W-1:0] iss_src_a, iss_src_b, iss_dst;
    logic [IMM_W-1:0] ins_imm, iss_imm;
    logic ins_busy, bc_valid, iss_valid, iss_fault;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_window i_issue_window (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic f, int rid, int a, logic ar, int b, logic br, int imm);
        ins_valid = 1'b1; ins_fault = f; ins_rid = RID_W'(rid); ins_op = OP_W'(rid + 1);
        ins_src_a = TAG_W'(a); ins_src_a_rdy = ar; ins_src_b = TAG_W'(b);
        ins_src_b_rdy = br; ins_imm = IMM_W'(imm); ins_dst = TAG_W'(rid + 2);
    endtask

    task automatic idle();
        ins_valid = 1'b0; ins_fault = 1'b0; ins_src_a_rdy = 1'b0; ins_src_b_rdy = 1'b0;
    endtask

    task automatic bcast(int tag);
        bc_valid = 1'b1; bc_tag = TAG_W'(tag);
    endtask

    task automatic expect_issue(string req, int rid);
        check(req, 32'(iss_valid), 1);
        check(req, 32'(iss_rid), 32'(rid));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; win_enable = 1'b0; bc_valid = 1'b0; bc_tag = '0;
        ins_rid = '0; ins_op = '0; ins_src_a = '0; ins_src_b = '0; ins_imm = '0; ins_dst = '0;
        idle();
        repeat (3) tick();
        check("R1 valid", 32'(iss_valid), 0);
        check("R1 busy", 32'(ins_busy), 0);
        rst_n = 1'b1;
        tick();
        check("R1 valid after", 32'(iss_valid), 0);
    endtask

    task automatic t_pass();
        drive(1'b0, 7, 9, 1'b0, 8, 1'b0, 16'hbeef);
        tick();
        idle();
        expect_issue("R2 pass", 7);
        check("R2 src_a", 32'(iss_src_a), 9);
        check("R2 imm", 32'(iss_imm), 32'hbeef);
        check("R2 dst", 32'(iss_dst), 9);
        check("R2 op", 32'(iss_op), 8);
        bcast(3);
        tick();
        bc_valid = 1'b0;
        check("R2 bcast ignored", 32'(iss_valid), 0);
        check("R2 busy", 32'(ins_busy), 0);
    endtask

    task automatic t_ready();
        win_enable = 1'b1;
        tick();
        drive(1'b0, 11, 1, 1'b1, 2, 1'b1, 16'h1234);
        tick();
        idle();
        check("R3 not yet", 32'(iss_valid), 0);
        tick();
        expect_issue("R3 issue", 11);
        check("R3 imm", 32'(iss_imm), 32'h1234);
        tick();
        check("R3 one shot", 32'(iss_valid), 0);
    endtask

    task automatic t_wait();
        drive(1'b0, 12, 5, 1'b0, 6, 1'b1, 0);
        tick();
        idle();
        tick();
        check("R4 held", 32'(iss_valid), 0);
        bcast(5);
        tick();
        bc_valid = 1'b0;
        check("R4 held b", 32'(iss_valid), 0);
        tick();
        expect_issue("R4 woken", 12);
    endtask

    task automatic t_same();
        drive(1'b0, 13, 1, 1'b1, 20, 1'b0, 0);
        bcast(20);
        tick();
        idle();
        bc_valid = 1'b0;
        check("R5 not yet", 32'(iss_valid), 0);
        tick();
        expect_issue("R5 same cycle wake", 13);
    endtask

    task automatic t_both();
        drive(1'b0, 14, 21, 1'b0, 22, 1'b0, 0);
        tick();
        idle();
        bcast(21);
        tick();
        bc_valid = 1'b0;
        tick();
        check("R6 one source", 32'(iss_valid), 0);
        bcast(22);
        tick();
        bc_valid = 1'b0;
        check("R6 held", 32'(iss_valid), 0);
        tick();
        expect_issue("R6 both", 14);
    endtask

    task automatic t_fault();
        drive(1'b1, 15, 40, 1'b0, 41, 1'b0, 0);
        tick();
        idle();
        check("R7 not yet", 32'(iss_valid), 0);
        tick();
        expect_issue("R7 fault", 15);
        check("R7 flag", 32'(iss_fault), 1);
        tick();
    endtask

    task automatic t_order();
        drive(1'b0, 1, 10, 1'b0, 0, 1'b1, 0);
        tick();
        drive(1'b0, 2, 10, 1'b0, 0, 1'b1, 0);
        check("R9 busy 1 used", 32'(ins_busy), 0);
        tick();
        drive(1'b0, 3, 12, 1'b0, 0, 1'b1, 0);
        check("R9 busy 2 used", 32'(ins_busy), 0);
        tick();
        check("R9 busy 3 used", 32'(ins_busy), 1);
        drive(1'b0, 4, 13, 1'b0, 0, 1'b1, 0);
        bcast(12);
        tick();
        idle();
        bc_valid = 1'b0;
        check("R9 busy full", 32'(ins_busy), 1);
        check("R8 nothing ready", 32'(iss_valid), 0);
        tick();
        expect_issue("R8 out of order", 3);
        bcast(10);
        tick();
        bc_valid = 1'b0;
        check("R8 gap", 32'(iss_valid), 0);
        tick();
        expect_issue("R8 lowest first", 1);
        check("R9 busy drops", 32'(ins_busy), 0);
        tick();
        expect_issue("R8 next", 2);
        bcast(13);
        tick();
        bc_valid = 1'b0;
        check("R8 single issue", 32'(iss_valid), 0);
        tick();
        expect_issue("R9 late arrival kept", 4);
        drive(1'b0, 5, 1, 1'b1, 2, 1'b1, 0);
        tick();
        idle();
        tick();
        expect_issue("R11 slot reuse", 5);
        tick();
    endtask

    task automatic t_drain();
        drive(1'b0, 30, 30, 1'b0, 0, 1'b1, 0);
        tick();
        idle();
        win_enable = 1'b0;
        tick();
        check("R10 busy drain", 32'(ins_busy), 1);
        tick();
        check("R10 held", 32'(iss_valid), 0);
        bcast(30);
        tick();
        bc_valid = 1'b0;
        check("R10 busy still", 32'(ins_busy), 1);
        tick();
        expect_issue("R10 drained", 30);
        check("R10 busy off", 32'(ins_busy), 0);
        drive(1'b0, 31, 50, 1'b0, 51, 1'b0, 0);
        tick();
        idle();
        expect_issue("R10 pass resumes", 31);
        tick();
    endtask

    initial begin
        t_reset();
        t_pass();
        t_ready();
        t_wait();
        t_same();
        t_both();
        t_fault();
        t_order();
        t_drain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule